// File: doc/BRIEF.md
# Seven-to-One Double-Data-Rate Output Serializer

This block turns a stream of 7-bit parallel words into a serial stream that carries two bits per cycle of a fast bit clock. One word is taken on every rising edge of the word clock. The bit clock runs at exactly three and a half times the word-clock rate, so a single word does not fill a whole number of bit-clock cycles. The block therefore groups words in pairs: each pair holds fourteen bits and fills exactly seven bit-clock cycles. Successive words start alternately on the first and second half of a bit-clock cycle.

The output is two single-rate signals that both change on the rising bit-clock edge. `bit_rise_o` holds the bit meant for the high half of the bit-clock cycle, and `bit_fall_o` holds the bit meant for the low half that follows. A double-data-rate output register outside the block merges them onto one line. Inside each word, bit 0 goes out first and bit 6 goes out last. The words leave in the order they were captured.

The word-clock side has a two-state slot machine. It has a state LOW (capture the first word of a pair) and a state HIGH (capture the second word, publish the pair and flip the pair flag). The transitions are *fill* (LOW to HIGH) and *publish* (HIGH to LOW). The bit-clock side has a three-state gearbox machine. IDLE is the reset state. The transition *arm* (IDLE to SEEK) follows unconditionally. SEEK waits for the synchronized pair flag to flip. The transition *lock* (SEEK to RUN) loads the first pair and starts a modulo-7 phase counter. In RUN, the transition *reload* (RUN to RUN, at phase 6) loads the next pair, and *drain* (RUN to RUN, other phases) shifts out two bits. Only reset leaves RUN.

Top module: `ser7_ddr_tx`

## Requirements
- R1: `word_i` is captured on each rising edge of `clk_word_i`. Bit 0 of a word is transmitted first and bit 6 last.
- R2: Each bit-clock cycle carries two consecutive stream bits. The earlier bit is on `bit_rise_o` and the next bit is on `bit_fall_o`. Both are updated on the rising edge of `clk_bit_i`.
- R3: Every seven bit-clock cycles in RUN carry exactly fourteen bits: two whole words in capture order, with no gap, repeat or idle bit between words.
- R4: The first word captured after reset is the first word transmitted.
- R5: While `reset_i` is high, and afterwards until the first pair has been loaded, both outputs are 0.
- R6: The first bit of the first word appears on `bit_rise_o` no more than 16 bit-clock cycles after reset is released.
- R7: Once locked, the gearbox reloads a pair exactly on the cycle in which the synchronized pair flag flips, which is phase 6 of its counter. It stays locked until reset. The word side publishes a new pair only together with a flag flip, and never flips the flag on two consecutive words.
- R8: A reset applied in mid-stream silences the outputs at once. After release, the block locks again and resumes with the first word captured after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word_i | input | 1 | Word clock; one parallel word per rising edge |
| clk_bit_i | input | 1 | Bit clock, phase-locked at 3.5 times the word-clock rate |
| reset_i | input | 1 | Asynchronous active-high reset for both clock domains |
| word_i | input | 7 | Parallel word; bit 0 is sent first |
| bit_rise_o | output | 1 | Stream bit for the high half of the current bit-clock cycle |
| bit_fall_o | output | 1 | Stream bit for the low half of the current bit-clock cycle |

## Verification
The assertions check several properties on every cycle. The outputs stay silent outside RUN. RUN is never left without reset. Each reload in RUN falls on phase 6 at the same moment as a synchronized flag flip. The word side changes its pair register only together with a flag flip, and flips the flag at most every second word. The bit order inside a word, the pairing of words across the half-cycle phase shift, the absence of gaps and repeats, the start-up latency and the restart after a mid-stream reset are visible only in the serial stream. The bench rebuilds that stream and compares each recovered word with what it applied, using directed patterns and random words.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

    // Word-clock side: which half of a pair the next word fills.
    typedef enum logic {
        SLOT_LOW  = 1'b0,
        SLOT_HIGH = 1'b1
    } slot_state_e;

    // Bit-clock side: gearbox lock state.
    typedef enum logic [1:0] {
        GB_IDLE = 2'd0,
        GB_SEEK = 2'd1,
        GB_RUN  = 2'd2
    } gb_state_e;

endpackage

// File: rtl/ser7_word_pair.sv
module ser7_word_pair
    import ser7_pkg::*;
#(
    parameter int WORD_W = 7
) (
    input  logic                  clk_word_i,
    input  logic                  reset_i,
    input  logic [WORD_W-1:0]     word_i,
    output logic [2*WORD_W-1:0]   pair_o,
    output logic                  pair_tog_o
);

    localparam int PAIR_W = 2 * WORD_W;

    slot_state_e        slot_q;
    slot_state_e        slot_d;
    logic [WORD_W-1:0]  first_q;

    // State register
    always_ff @(posedge clk_word_i or posedge reset_i) begin
        if (reset_i) begin
            slot_q <= SLOT_LOW;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Transitions: fill (LOW->HIGH), publish (HIGH->LOW)
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_LOW:  slot_d = SLOT_HIGH;
            SLOT_HIGH: slot_d = SLOT_LOW;
            default:   slot_d = SLOT_LOW;
        endcase
    end

    // Data and flag, per state
    always_ff @(posedge clk_word_i or posedge reset_i) begin
        if (reset_i) begin
            first_q    <= '0;
            pair_o     <= '0;
            pair_tog_o <= 1'b0;
        end else begin
            unique case (slot_q)
                SLOT_LOW: begin
                    first_q <= word_i;
                end
                SLOT_HIGH: begin
                    // earlier word in the low half: it leaves first
                    pair_o     <= {word_i, first_q};
                    pair_tog_o <= ~pair_tog_o;
                end
                default: begin
                    first_q <= first_q;
                end
            endcase
        end
    end

    // R7
    pair_with_flag_chk: assert property (@(posedge clk_word_i) disable iff (reset_i)
        !$stable(pair_o) |-> !$stable(pair_tog_o));

    // R7
    flag_spacing_chk: assert property (@(posedge clk_word_i) disable iff (reset_i)
        !$stable(pair_tog_o) |=> $stable(pair_tog_o));

endmodule

// File: rtl/ser7_flag_sync.sv
module ser7_flag_sync #(
    parameter int STAGES = 3
) (
    input  logic clk_bit_i,
    input  logic reset_i,
    input  logic flag_i,
    output logic flip_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_bit_i or posedge reset_i) begin
        if (reset_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], flag_i};
        end
    end

    // one-cycle pulse on each change of the flag, taken past the first stage
    assign flip_o = chain_q[LAST] ^ chain_q[LAST-1];

endmodule

// File: rtl/ser7_gearbox.sv
module ser7_gearbox
    import ser7_pkg::*;
#(
    parameter int WORD_W = 7
) (
    input  logic                  clk_bit_i,
    input  logic                  reset_i,
    input  logic [2*WORD_W-1:0]   pair_i,
    input  logic                  flip_i,
    output logic                  bit_rise_o,
    output logic                  bit_fall_o
);

    localparam int PAIR_W  = 2 * WORD_W;
    localparam int PHASES  = PAIR_W / 2;
    localparam int PH_W    = $clog2(PHASES);
    localparam int REST_W  = PAIR_W - 2;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    gb_state_e          state_q;
    gb_state_e          state_d;
    logic [PH_W-1:0]    phase_q;
    logic [REST_W-1:0]  stage_q;

    // State register
    always_ff @(posedge clk_bit_i or posedge reset_i) begin
        if (reset_i) begin
            state_q <= GB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, lock, reload/drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GB_IDLE: state_d = GB_SEEK;
            GB_SEEK: if (flip_i) state_d = GB_RUN;
            GB_RUN:  state_d = GB_RUN;
            default: state_d = GB_IDLE;
        endcase
    end

    // Outputs, phase counter and staging register
    always_ff @(posedge clk_bit_i or posedge reset_i) begin
        if (reset_i) begin
            phase_q    <= '0;
            stage_q    <= '0;
            bit_rise_o <= 1'b0;
            bit_fall_o <= 1'b0;
        end else begin
            unique case (state_q)
                GB_IDLE: begin
                    phase_q    <= '0;
                    bit_rise_o <= 1'b0;
                    bit_fall_o <= 1'b0;
                end
                GB_SEEK: begin
                    if (flip_i) begin
                        bit_rise_o <= pair_i[0];
                        bit_fall_o <= pair_i[1];
                        stage_q    <= pair_i[PAIR_W-1:2];
                        phase_q    <= '0;
                    end
                end
                GB_RUN: begin
                    if (phase_q == LAST_PH) begin
                        bit_rise_o <= pair_i[0];
                        bit_fall_o <= pair_i[1];
                        stage_q    <= pair_i[PAIR_W-1:2];
                        phase_q    <= '0;
                    end else begin
                        bit_rise_o <= stage_q[0];
                        bit_fall_o <= stage_q[1];
                        stage_q    <= {2'b00, stage_q[REST_W-1:2]};
                        phase_q    <= phase_q + PH_W'(1);
                    end
                end
                default: begin
                    bit_rise_o <= 1'b0;
                    bit_fall_o <= 1'b0;
                end
            endcase
        end
    end

    // R7
    lock_phase_chk: assert property (@(posedge clk_bit_i) disable iff (reset_i)
        (state_q == GB_RUN && flip_i) |-> (phase_q == LAST_PH));

    // R7
    reload_on_flip_chk: assert property (@(posedge clk_bit_i) disable iff (reset_i)
        (state_q == GB_RUN && phase_q == LAST_PH) |-> flip_i);

    // R7
    run_sticky_chk: assert property (@(posedge clk_bit_i) disable iff (reset_i)
        (state_q == GB_RUN) |=> (state_q == GB_RUN));

    // R5
    quiet_until_run_chk: assert property (@(posedge clk_bit_i) disable iff (reset_i)
        (state_q != GB_RUN) |-> (!bit_rise_o && !bit_fall_o));

    // R3
    phase_range_chk: assert property (@(posedge clk_bit_i) disable iff (reset_i)
        phase_q <= LAST_PH);

endmodule

// File: rtl/ser7_ddr_tx.sv
module ser7_ddr_tx #(
    parameter int WORD_W      = 7,
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk_word_i,
    input  logic              clk_bit_i,
    input  logic              reset_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_rise_o,
    output logic              bit_fall_o
);

    localparam int PAIR_W = 2 * WORD_W;

    logic [PAIR_W-1:0] pair_w;
    logic              pair_tog_w;
    logic              flip_w;

    ser7_word_pair #(
        .WORD_W (WORD_W)
    ) pair_i (
        .clk_word_i (clk_word_i),
        .reset_i    (reset_i),
        .word_i     (word_i),
        .pair_o     (pair_w),
        .pair_tog_o (pair_tog_w)
    );

    ser7_flag_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_bit_i (clk_bit_i),
        .reset_i   (reset_i),
        .flag_i    (pair_tog_w),
        .flip_o    (flip_w)
    );

    ser7_gearbox #(
        .WORD_W (WORD_W)
    ) gear_i (
        .clk_bit_i  (clk_bit_i),
        .reset_i    (reset_i),
        .pair_i     (pair_w),
        .flip_i     (flip_w),
        .bit_rise_o (bit_rise_o),
        .bit_fall_o (bit_fall_o)
    );

endmodule

// File: tb/ser7_ddr_tx_tb_top.sv
`timescale 1ns/1ps
module ser7_ddr_tx_tb_top;

    localparam int N_CHECK = 150;
    localparam int WD_LIMIT = 100000;

    logic       clk_word = 1'b0;
    logic       clk_bit  = 1'b0;
    logic       reset    = 1'b1;
    logic [6:0] word     = '0;
    logic       bit_rise;
    logic       bit_fall;

    int checks = 0;
    int fails  = 0;
    int tick   = 0;
    bit mon_done = 1'b0;
    logic [6:0] wbuf [0:511];

    ser7_ddr_tx dut_i (
        .clk_word_i (clk_word),
        .clk_bit_i  (clk_bit),
        .reset_i    (reset),
        .word_i     (word),
        .bit_rise_o (bit_rise),
        .bit_fall_o (bit_fall)
    );

    // 2 ns base tick: bit clock 8 ns (125 MHz), word clock 28 ns (ratio 3.5)
    initial begin
        forever begin
            #2;
            tick++;
            if (tick % 2 == 0) clk_bit = ~clk_bit;
            if (tick % 7 == 0) clk_word = ~clk_word;
        end
    end

    // watchdog
    initial begin
        for (int i = 0; i < WD_LIMIT; i++) @(posedge clk_bit);
        fails++;
        $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", WD_LIMIT, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic logic [6:0] rand_word();
        return 7'($urandom());
    endfunction

    task automatic check_bit(input string req, input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: %s got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic fill_words(input logic [6:0] first);
        wbuf[0] = first;             // bit 0 set: marks the stream start
        wbuf[1] = 7'h00;
        wbuf[2] = 7'h7F;
        wbuf[3] = 7'h01;             // walking one, first position
        wbuf[4] = 7'h40;             // walking one, last position
        wbuf[5] = 7'h02;             // lands on the fall half
        wbuf[6] = 7'h2A;
        wbuf[7] = 7'h15;
        for (int i = 8; i < 512; i++) wbuf[i] = rand_word();
    endtask

    task automatic drive_words();
        int idx = 1;
        while (!mon_done) begin
            @(negedge clk_word);
            word = wbuf[idx];
            if (idx < 511) idx++;
        end
    endtask

    task automatic monitor_stream();
        int   got_words = 0;
        int   cyc = 0;
        int   nb = 0;
        bit   locked = 1'b0;
        logic [6:0] acc = '0;
        logic b;
        while (got_words < N_CHECK) begin
            @(posedge clk_bit);
            #2;
            cyc++;
            if (!locked) begin
                if (bit_rise) begin
                    locked = 1'b1;
                    checks++;
                    if (cyc > 16) begin
                        fails++;
                        $display("FAIL R6: first bit after %0d cycles expected <= 16", cyc);
                    end
                end else begin
                    // R5: silent before the first pair; R2: start on the rise half
                    check_bit("R5", bit_fall, 1'b0, "pre-lock fall bit");
                    if (cyc > 40) begin
                        fails++;
                        $display("FAIL R6: no stream start after %0d cycles expected <= 16", cyc);
                        break;
                    end
                end
            end
            if (locked) begin
                for (int k = 0; k < 2; k++) begin
                    b = (k == 0) ? bit_rise : bit_fall;
                    acc[nb] = b;
                    nb++;
                    if (nb == 7) begin
                        checks++;
                        if (acc !== wbuf[got_words]) begin
                            fails++;
                            if (got_words == 0)
                                $display("FAIL R4: word 0 got %h expected %h", acc, wbuf[0]);
                            else
                                $display("FAIL R1/R2/R3: word %0d got %h expected %h",
                                         got_words, acc, wbuf[got_words]);
                        end
                        got_words++;
                        nb = 0;
                        if (got_words >= N_CHECK) break;
                    end
                end
            end
        end
        mon_done = 1'b1;
    endtask

    task automatic run_session();
        mon_done = 1'b0;
        @(negedge clk_word);
        #2;
        reset = 1'b0;
        fork
            drive_words();
            monitor_stream();
        join
    endtask

    initial begin
        void'($urandom(32'd1357));

        // session 1: power-up reset
        fill_words(7'h55);
        word = wbuf[0];
        repeat (5) @(posedge clk_bit);
        #2;
        check_bit("R5", bit_rise, 1'b0, "rise bit in reset");
        check_bit("R5", bit_fall, 1'b0, "fall bit in reset");
        run_session();

        // session 2: mid-stream reset (R8)
        @(posedge clk_bit);
        #2;
        reset = 1'b1;
        #1;
        check_bit("R8", bit_rise, 1'b0, "rise bit right after mid-stream reset");
        check_bit("R8", bit_fall, 1'b0, "fall bit right after mid-stream reset");
        fill_words(7'h4B);
        word = wbuf[0];
        repeat (4) @(posedge clk_bit);
        #2;
        check_bit("R5", bit_rise, 1'b0, "rise bit held in reset");
        check_bit("R5", bit_fall, 1'b0, "fall bit held in reset");
        run_session();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule